// File: doc/BRIEF.md
# Indirect command register bridge

This block answers a host that can only reach two registers: a command word and a data word. The host does not touch the internal register space directly. It loads the data word, then writes a command that names a device and a register inside a 32 x 32 word space. The bridge holds the busy bit high while the deferred access runs, then clears it. For a read, the fetched value is left in the data word. The host learns that the access has finished by polling the busy bit. A parameter sets how long the internal space takes to respond, so hosts that poll can be tested.

Device 0x1C is special. Its registers 0x18 and 0x19 hold no storage. They are the command and data words of a second bridge of the same kind, and that second bridge reaches a separate PHY register space. In a command written to this inner pair, the device field selects the PHY number. The inner bridge has its own latency parameter.

Top module: `ind_bridge`

## Requirements
- R1: The command word layout is: bit 15 go/busy, bit 12 clause-22 flag, bits 11:10 opcode (2 = read, 1 = write), bits 9:5 device, bits 4:0 register. Reading the command word returns bits 14:0 as last accepted, with the live busy state in bit 15.
- R2: A write command stores the current data word into the addressed location of the register space.
- R3: A read command loads the addressed location into the data word by the time busy reads 0.
- R4: A valid command is accepted when bit 15 is written as 1. Busy then reads 1 for exactly MAIN_LATENCY+2 clock cycles and reads 0 after that.
- R5: A command written while busy is set is ignored. It does not change the command word and performs no access.
- R6: A command written with bit 15 set completes at once with no effect when it carries an opcode other than 1 or 2, or has bit 12 clear. Busy is never seen set, and neither the data word nor the register space changes.
- R7: A command written with bit 15 clear is stored and read back, but it starts no access.
- R8: A write to the data word while busy is set is ignored.
- R9: Device 0x1C, register 0x18 (command) and register 0x19 (data), form an inner pair with the same encoding. An inner command reads or writes the PHY space at the PHY number given in its device field. The inner busy bit stays set for PHY_LATENCY+2 cycles.
- R10: Host reads return data one cycle after host_rd (host_sel 0 = command word, 1 = data word). After reset both words read 0.
- R11: The PHY space and the main space are independent. Device 0x1C, registers 0x18 and 0x19, hold no main-space storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 selects the command word, 1 selects the data word |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data, valid the cycle after host_rd |

## Verification
The hardest state to reach is the inner PHY bridge still being busy when the host looks at it. The outer access that reads the inner command word adds its own latency, so the inner busy window usually closes first. The bench sets the PHY latency well above the outer latency. It reads the inner command word right after an inner command is issued, and checks that the busy bit is caught high at least once before it clears. Commands that are ignored, or that complete at once, are checked through later readback of the command word, the data word and the targeted locations.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  localparam int WORD_W   = 16;
  localparam int FLD_W    = 5;
  localparam int ADDR_W   = 2 * FLD_W;
  localparam int GO_BIT   = 15;
  localparam int C22_BIT  = 12;
  localparam logic [1:0] OP_RD = 2'd2;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [FLD_W-1:0] NEST_DEV  = 5'h1C;
  localparam logic [FLD_W-1:0] NEST_CMD  = 5'h18;
  localparam logic [FLD_W-1:0] NEST_DATA = 5'h19;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACCESS,
    ST_DONE
  } eng_state_t;

  function automatic logic cmd_valid(input logic [WORD_W-1:0] w);
    return w[C22_BIT] && (w[11:10] == OP_RD || w[11:10] == OP_WR);
  endfunction
endpackage

// File: rtl/ind_reg_store.sv
module ind_reg_store #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/ind_cmd_engine.sv
module ind_cmd_engine
  import ind_bridge_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic              h_sel,
  input  logic [WORD_W-1:0] h_wdata,
  output logic [WORD_W-1:0] h_rdata,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] cmd_val,
  output logic [WORD_W-1:0] data_val,
  output logic              t_req,
  output logic              t_we,
  output logic [ADDR_W-1:0] t_addr,
  output logic [WORD_W-1:0] t_wdata,
  input  logic [WORD_W-1:0] t_rdata
);
  localparam int CW = (LATENCY < 2) ? 1 : $clog2(LATENCY);

  eng_state_t        state;
  logic [CW-1:0]     cnt;
  logic [WORD_W-2:0] cmd_q;
  logic [WORD_W-1:0] data_q;

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign cmd_val  = {busy, cmd_q};
  assign data_val = data_q;
  assign t_req    = (state == ST_ACCESS);
  assign t_we     = (cmd_q[11:10] == OP_WR);
  assign t_addr   = cmd_q[ADDR_W-1:0];
  assign t_wdata  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      h_rdata <= '0;
    end else begin
      if (h_rd) h_rdata <= h_sel ? data_q : {busy, cmd_q};
      unique case (state)
        ST_IDLE: begin
          if (h_wr && h_sel) data_q <= h_wdata;
          if (h_wr && !h_sel) begin
            cmd_q <= h_wdata[WORD_W-2:0];
            if (h_wdata[GO_BIT] && cmd_valid(h_wdata)) begin
              if (LATENCY == 0) begin
                state <= ST_ACCESS;
              end else begin
                state <= ST_WAIT;
                cnt   <= CW'(LATENCY - 1);
              end
            end
          end
        end
        ST_WAIT: begin
          if (cnt == '0) state <= ST_ACCESS;
          else           cnt   <= cnt - 1'b1;
        end
        ST_ACCESS: state <= ST_DONE;
        ST_DONE: begin
          if (!t_we) data_q <= t_rdata;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ind_bridge.sv
module ind_bridge
  import ind_bridge_pkg::*;
#(
  parameter int MAIN_LATENCY = 3,
  parameter int PHY_LATENCY  = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic        host_sel,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata
);
  logic              eng_busy, eng_done, eng_t_req, eng_t_we;
  logic [ADDR_W-1:0] eng_addr;
  logic [WORD_W-1:0] eng_wdata, eng_rdata, eng_cmd, eng_data;
  logic [WORD_W-1:0] main_rdata, phy_h_rdata;
  logic              hit_phy, rd_from_phy;

  logic              phy_busy, phy_done, phy_t_req, phy_t_we;
  logic [ADDR_W-1:0] phy_addr;
  logic [WORD_W-1:0] phy_wdata, phy_rdata, phy_cmd, phy_data;

  ind_cmd_engine #(.LATENCY(MAIN_LATENCY)) u_host_eng (
    .clk(clk), .rst(rst),
    .h_wr(host_wr), .h_rd(host_rd), .h_sel(host_sel), .h_wdata(host_wdata),
    .h_rdata(host_rdata), .busy(eng_busy), .done(eng_done),
    .cmd_val(eng_cmd), .data_val(eng_data),
    .t_req(eng_t_req), .t_we(eng_t_we), .t_addr(eng_addr),
    .t_wdata(eng_wdata), .t_rdata(eng_rdata)
  );

  assign hit_phy = (eng_addr[ADDR_W-1:FLD_W] == NEST_DEV) &&
                   (eng_addr[FLD_W-1:0] == NEST_CMD || eng_addr[FLD_W-1:0] == NEST_DATA);

  always_ff @(posedge clk) begin
    if (rst)            rd_from_phy <= 1'b0;
    else if (eng_t_req) rd_from_phy <= hit_phy;
  end

  assign eng_rdata = rd_from_phy ? phy_h_rdata : main_rdata;

  ind_reg_store #(.AW(ADDR_W), .DW(WORD_W)) u_main_store (
    .clk(clk), .en(eng_t_req && !hit_phy), .we(eng_t_we),
    .addr(eng_addr), .wdata(eng_wdata), .rdata(main_rdata)
  );

  ind_cmd_engine #(.LATENCY(PHY_LATENCY)) u_phy_eng (
    .clk(clk), .rst(rst),
    .h_wr(eng_t_req && eng_t_we && hit_phy),
    .h_rd(eng_t_req && !eng_t_we && hit_phy),
    .h_sel(eng_addr[FLD_W-1:0] == NEST_DATA),
    .h_wdata(eng_wdata), .h_rdata(phy_h_rdata),
    .busy(phy_busy), .done(phy_done), .cmd_val(phy_cmd), .data_val(phy_data),
    .t_req(phy_t_req), .t_we(phy_t_we), .t_addr(phy_addr),
    .t_wdata(phy_wdata), .t_rdata(phy_rdata)
  );

  ind_reg_store #(.AW(ADDR_W), .DW(WORD_W)) u_phy_store (
    .clk(clk), .en(phy_t_req), .we(phy_t_we),
    .addr(phy_addr), .wdata(phy_wdata), .rdata(phy_rdata)
  );
endmodule

// File: rtl/ind_bridge_chk.sv
module ind_bridge_chk
  import ind_bridge_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        host_wr,
  input logic        host_sel,
  input logic [15:0] host_wdata,
  input logic        eng_busy,
  input logic        eng_done,
  input logic        eng_t_req,
  input logic        eng_t_we,
  input logic        hit_phy,
  input logic [15:0] eng_cmd,
  input logic [15:0] eng_data,
  input logic        phy_busy,
  input logic        phy_done,
  input logic [15:0] phy_cmd,
  input logic [15:0] phy_data
);
  assert_busy_holds_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |=> eng_busy);

  assert_done_releases_R3: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> !eng_busy);

  assert_access_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
    eng_t_req |-> eng_busy);

  assert_cmd_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && host_wr && !host_sel) |=> $stable(eng_cmd[14:0]));

  assert_data_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && !eng_done && host_wr && host_sel) |=> $stable(eng_data));

  assert_bad_cmd_quick_R6: assert property (@(posedge clk) disable iff (rst)
    (!eng_busy && host_wr && !host_sel && host_wdata[15] && !cmd_valid(host_wdata))
      |=> !eng_busy);

  assert_phy_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_busy) |-> $past(eng_t_req && eng_t_we && hit_phy));

  assert_phy_cmd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (phy_busy && $past(phy_busy)) |-> $stable(phy_cmd[14:0]));

  assert_phy_data_src_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(phy_data) |-> $past(phy_done || (eng_t_req && eng_t_we && hit_phy)));
endmodule

bind ind_bridge ind_bridge_chk u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_sel(host_sel),
  .host_wdata(host_wdata), .eng_busy(eng_busy), .eng_done(eng_done),
  .eng_t_req(eng_t_req), .eng_t_we(eng_t_we), .hit_phy(hit_phy),
  .eng_cmd(eng_cmd), .eng_data(eng_data), .phy_busy(phy_busy),
  .phy_done(phy_done), .phy_cmd(phy_cmd), .phy_data(phy_data)
);

// File: tb/ind_bridge_test.sv
`timescale 1ns/1ps
module ind_bridge_test;
  localparam int LAT  = 3;
  localparam int PLAT = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  int total = 0, bad = 0;
  logic [15:0] main_m [1024];

  always #5 clk = ~clk;

  ind_bridge #(.MAIN_LATENCY(LAT), .PHY_LATENCY(PLAT)) uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  function automatic logic [15:0] mk(input logic [1:0] op, input logic [4:0] dev,
                                     input logic [4:0] rg, input logic c22, input logic go);
    return {go, 2'b00, c22, op, dev, rg};
  endfunction

  function automatic logic nested(input logic [4:0] dev, input logic [4:0] rg);
    return dev == 5'h1C && (rg == 5'h18 || rg == 5'h19);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic s, input logic [15:0] v);
    @(negedge clk); host_wr = 1'b1; host_sel = s; host_wdata = v;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hr(input logic s, output logic [15:0] v);
    @(negedge clk); host_rd = 1'b1; host_sel = s;
    @(negedge clk); host_rd = 1'b0; v = host_rdata;
  endtask

  task automatic poll(output int n);
    n = 0; host_rd = 1'b1; host_sel = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (host_rdata[15]) n++;
      else break;
    end
    host_rd = 1'b0;
  endtask

  task automatic mwrite(input logic [4:0] dev, input logic [4:0] rg, input logic [15:0] val);
    int n;
    hw(1'b1, val);
    hw(1'b0, mk(2'd1, dev, rg, 1'b1, 1'b1));
    poll(n);
    chk(n == LAT + 2, "R4 busy length", 16'(n), 16'(LAT + 2));
    if (!nested(dev, rg)) main_m[{dev, rg}] = val;
  endtask

  task automatic mread(input logic [4:0] dev, input logic [4:0] rg, output logic [15:0] v);
    int n;
    hw(1'b0, mk(2'd2, dev, rg, 1'b1, 1'b1));
    poll(n);
    hr(1'b1, v);
  endtask

  task automatic phy_wait(input logic [15:0] exp_cmd);
    logic [15:0] v;
    mread(5'h1C, 5'h18, v);
    chk(v[15] == 1'b1, "R9 inner busy seen", v, exp_cmd | 16'h8000);
    for (int i = 0; i < 20 && v[15]; i++) mread(5'h1C, 5'h18, v);
    chk(v == exp_cmd, "R9 inner cmd readback", v, exp_cmd);
  endtask

  task automatic phy_access(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] val, output logic [15:0] got);
    if (wr) mwrite(5'h1C, 5'h19, val);
    mwrite(5'h1C, 5'h18, mk(wr ? 2'd1 : 2'd2, phy, rg, 1'b1, 1'b1));
    phy_wait(mk(wr ? 2'd1 : 2'd2, phy, rg, 1'b1, 1'b0));
    mread(5'h1C, 5'h19, got);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog R4 act=timeout exp=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v, d;
    int n;
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < 1024; i++) main_m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    hr(1'b0, v); chk(v == 16'h0, "R10 reset command word", v, 16'h0);
    hr(1'b1, v); chk(v == 16'h0, "R10 reset data word", v, 16'h0);

    mwrite(5'd3, 5'd7, 16'hA5A5);
    mread(5'd3, 5'd7, v); chk(v == 16'hA5A5, "R2 R3 write then read", v, 16'hA5A5);
    hr(1'b0, v); chk(v == mk(2'd2, 5'd3, 5'd7, 1'b1, 1'b0), "R1 command readback", v,
                     mk(2'd2, 5'd3, 5'd7, 1'b1, 1'b0));

    // R5: second command during busy
    hw(1'b1, 16'h1111);
    hw(1'b0, mk(2'd1, 5'd4, 5'd1, 1'b1, 1'b1));
    hw(1'b0, mk(2'd1, 5'd4, 5'd2, 1'b1, 1'b1));
    poll(n);
    main_m[{5'd4, 5'd1}] = 16'h1111;
    hr(1'b0, v); chk(v == mk(2'd1, 5'd4, 5'd1, 1'b1, 1'b0), "R5 command kept", v,
                     mk(2'd1, 5'd4, 5'd1, 1'b1, 1'b0));
    mread(5'd4, 5'd2, v); chk(v == 16'h0, "R5 ignored target untouched", v, 16'h0);
    mread(5'd4, 5'd1, v); chk(v == 16'h1111, "R5 first command done", v, 16'h1111);

    // R8: data write during busy
    hw(1'b1, 16'h2222);
    hw(1'b0, mk(2'd1, 5'd6, 5'd6, 1'b1, 1'b1));
    hw(1'b1, 16'h3333);
    poll(n);
    main_m[{5'd6, 5'd6}] = 16'h2222;
    hr(1'b1, v); chk(v == 16'h2222, "R8 data word kept", v, 16'h2222);
    mread(5'd6, 5'd6, v); chk(v == 16'h2222, "R8 stored original data", v, 16'h2222);

    // R6: bad opcode and clause flag clear
    hw(1'b1, 16'h4444);
    hw(1'b0, mk(2'd3, 5'd8, 5'd8, 1'b1, 1'b1));
    poll(n); chk(n == 0, "R6 bad opcode no busy", 16'(n), 16'h0);
    hw(1'b0, mk(2'd1, 5'd8, 5'd8, 1'b0, 1'b1));
    poll(n); chk(n == 0, "R6 clause flag clear no busy", 16'(n), 16'h0);
    hr(1'b1, v); chk(v == 16'h4444, "R6 data unchanged", v, 16'h4444);
    mread(5'd8, 5'd8, v); chk(v == 16'h0, "R6 no write performed", v, 16'h0);

    // R7: go bit clear
    hw(1'b1, 16'h5555);
    hw(1'b0, mk(2'd1, 5'd9, 5'd9, 1'b1, 1'b0));
    poll(n); chk(n == 0, "R7 no busy", 16'(n), 16'h0);
    hr(1'b0, v); chk(v == mk(2'd1, 5'd9, 5'd9, 1'b1, 1'b0), "R7 stored word", v,
                     mk(2'd1, 5'd9, 5'd9, 1'b1, 1'b0));
    mread(5'd9, 5'd9, v); chk(v == 16'h0, "R7 no access", v, 16'h0);

    // R9 / R11: nested PHY pair
    phy_access(1'b1, 5'd5, 5'd16, 16'hBEEF, d);
    phy_access(1'b1, 5'd7, 5'd3, 16'h0C0C, d);
    phy_access(1'b0, 5'd5, 5'd16, 16'h0, d);
    chk(d == 16'hBEEF, "R9 phy 5 read", d, 16'hBEEF);
    phy_access(1'b0, 5'd7, 5'd3, 16'h0, d);
    chk(d == 16'h0C0C, "R9 phy 7 read", d, 16'h0C0C);
    mread(5'd5, 5'd16, v); chk(v == 16'h0, "R11 main space separate", v, 16'h0);
    mwrite(5'd5, 5'd16, 16'h7777);
    phy_access(1'b0, 5'd5, 5'd16, 16'h0, d);
    chk(d == 16'hBEEF, "R11 phy space separate", d, 16'hBEEF);

    // random traffic on the main space
    for (int it = 0; it < 150; it++) begin
      logic [4:0] dev, rg;
      logic [15:0] val;
      int kind;
      dev = 5'($urandom_range(0, 31));
      rg = 5'($urandom_range(0, 31));
      if (nested(dev, rg)) rg = 5'd0;
      val = 16'($urandom);
      kind = $urandom_range(0, 9);
      if (kind < 5) begin
        mwrite(dev, rg, val);
      end else if (kind < 9) begin
        mread(dev, rg, v);
        chk(v == main_m[{dev, rg}], "R3 random read", v, main_m[{dev, rg}]);
      end else begin
        hw(1'b0, mk(2'd0, dev, rg, 1'b1, 1'b1));
        poll(n); chk(n == 0, "R6 random null opcode", 16'(n), 16'h0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule